// File: doc/BRIEF.md
# Daisy-Chain Pipelined Bus Arbiter

This block decides which of N masters owns a shared system bus. A grant token enters the head of a serial chain of per-device cells whenever any device is requesting. Each cell either absorbs the token, if its own device is requesting, or passes it on to the next cell. The first requesting cell along the chain wins, so the chain position sets a fixed priority. Index 0 sits at the head and ranks highest.

Arbitration runs on its own logic, in parallel with the transfer in progress. The chain is resolved combinationally and sampled once per clock into a registered next-owner value. That value becomes the one-hot bus grant on the clock edge where the current master signals the end of its transfer. When no one holds the bus, it becomes the grant on the next edge. If nobody was requesting, the bus falls idle when the transfer ends.

Top module: `daisy_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every bus grant and the captured next owner. After reset is released with no requests pending, all grants stay 0.
- R2: At most one bit of `bus_gnt` is 1 in any cycle.
- R3: Among the requests sampled on one edge, the lowest index wins (index 0 has the highest priority).
- R4: While the bus is idle (all grants 0), a request vector sampled on clock edge k drives the winner's grant bit high after edge k+1.
- R5: While some grant is high and `xfer_done` is 0, the grant vector holds its value whatever the requests do.
- R6: When `xfer_done` is 1 on edge k, the grant after edge k goes to the winner of the requests sampled on edge k-1. A request present earlier but dropped by edge k-1 is not counted.
- R7: When `xfer_done` is 1 on edge k and no request was sampled on edge k-1, all grants are 0 after edge k.
- R8: `xfer_done` while the bus is idle has no effect: the grants still follow R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Per-device bus request, bit 0 highest priority |
| xfer_done | input | 1 | Current owner ends its utilization period |
| bus_gnt | output | N | One-hot bus ownership, all zero when idle |

## Verification
The bench changes the requests while a transfer is still running. A design that let the grant follow the live chain would hand over the bus mid-transfer. It checks the handoff after a request was withdrawn one cycle before `xfer_done`. A design that latched requests rather than resampling them would grant a device that no longer wants the bus. It ends a transfer with nothing pending to confirm the bus drops to idle rather than regranting the old owner, and it tests all-requesting patterns to catch a reversed chain order. A reset during ownership must clear the pending winner as well as the grant, otherwise a stale owner appears after release.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        PHASE_IDLE = 1'b0,
        PHASE_BUSY = 1'b1
    } bus_phase_e;
endpackage

// File: rtl/arb_chain_cell.sv
module arb_chain_cell (
    input  logic tok_in,
    input  logic want,
    output logic tok_out,
    output logic won
);
    // absorb the token when requesting, otherwise forward it downstream
    assign won     = tok_in & want;
    assign tok_out = tok_in & ~want;
endmodule

// File: rtl/arb_grant_chain.sv
module arb_grant_chain #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] winner
);
    localparam int LINKS = N + 1;

    logic [LINKS-1:0] tok;

    // head of chain: token present whenever anyone requests
    assign tok[0] = |req;

    for (genvar i = 0; i < N; i++) begin : g_cell
        arb_chain_cell u_cell (
            .tok_in (tok[i]),
            .want   (req[i]),
            .tok_out(tok[i+1]),
            .won    (winner[i])
        );
    end

    always_comb begin
        AST_CHAIN_SINGLE_WIN: assert ($onehot0(winner)); // R3
        AST_CHAIN_WIN_IF_ANY: assert ((req == '0) || (winner != '0)); // R3
    end
endmodule

// File: rtl/daisy_bus_arbiter.sv
module daisy_bus_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         xfer_done,
    output logic [N-1:0] bus_gnt
);
    import arb_pkg::*;

    typedef struct packed {
        logic [N-1:0] next_own;
        logic [N-1:0] gnt;
    } arb_state_t;

    logic [N-1:0] chain_win;
    bus_phase_e   phase;
    arb_state_t   st_d, st_q;

    arb_grant_chain #(.N(N)) u_chain (
        .req   (req),
        .winner(chain_win)
    );

    assign phase   = (st_q.gnt != '0) ? PHASE_BUSY : PHASE_IDLE;
    assign bus_gnt = st_q.gnt;

    always_comb begin
        st_d          = st_q;
        st_d.next_own = chain_win;
        if (phase == PHASE_IDLE || xfer_done) begin
            st_d.gnt = st_q.next_own;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst) $onehot0(bus_gnt)); // R2
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt != '0 && !xfer_done) |=> $stable(bus_gnt)); // R5
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && st_q.next_own == '0) |=> (bus_gnt == '0)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (bus_gnt == '0 && st_q.next_own == '0)); // R1
    AST_NEXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_q.next_own)); // R3
endmodule

// File: tb/daisy_bus_arbiter_test.sv
module daisy_bus_arbiter_test;
    localparam int N = 4;
    localparam int STEPS = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req;
    logic         xfer_done;
    logic [N-1:0] bus_gnt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // {requirement id, req, xfer_done, expected grant after the edge}
    typedef struct packed {
        logic [3:0]   rid;
        logic [N-1:0] rq;
        logic         dn;
        logic [N-1:0] exp;
    } vec_t;

    localparam vec_t VECS [STEPS] = '{
        '{4'd4, 4'b0100, 1'b0, 4'b0000}, // R4 request captured, no grant yet
        '{4'd4, 4'b0000, 1'b0, 4'b0100}, // R4 grant one edge later on idle bus
        '{4'd5, 4'b0011, 1'b0, 4'b0100}, // R5 hold while busy
        '{4'd5, 4'b0010, 1'b0, 4'b0100}, // R5 hold, device 0 withdraws
        '{4'd6, 4'b1010, 1'b1, 4'b0010}, // R6 withdrawn device 0 not counted
        '{4'd6, 4'b1000, 1'b1, 4'b0010}, // R6 owner re-wins
        '{4'd6, 4'b0000, 1'b1, 4'b1000}, // R6 handoff to device 3
        '{4'd7, 4'b0000, 1'b1, 4'b0000}, // R7 nothing pending, bus idle
        '{4'd8, 4'b0000, 1'b1, 4'b0000}, // R8 done on idle bus ignored
        '{4'd3, 4'b1111, 1'b0, 4'b0000}, // R3 all request
        '{4'd3, 4'b1110, 1'b0, 4'b0001}, // R3 index 0 wins
        '{4'd3, 4'b1100, 1'b1, 4'b0010}, // R3 index 1 next
        '{4'd3, 4'b1000, 1'b1, 4'b0100}, // R3 index 2 next
        '{4'd6, 4'b0000, 1'b1, 4'b1000}, // R6 last pending device
        '{4'd5, 4'b0000, 1'b0, 4'b1000}, // R5 hold without done
        '{4'd7, 4'b0000, 1'b1, 4'b0000}  // R7 release to idle
    };

    daisy_bus_arbiter #(.N(N)) uut (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .xfer_done(xfer_done),
        .bus_gnt  (bus_gnt)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [N-1:0] exp);
        checks++;
        if (bus_gnt !== exp) begin
            fails++;
            $display("FAIL %s: bus_gnt=%b expected=%b", tag, bus_gnt, exp);
        end
        checks++;
        if (!$onehot0(bus_gnt)) begin
            fails++;
            $display("FAIL R2: bus_gnt=%b expected at most one bit", bus_gnt);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic d);
        @(negedge clk);
        req       = r;
        xfer_done = d;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run did not end");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        req       = '0;
        xfer_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 4'b0000);
        step(4'b0000, 1'b0);
        rst = 1'b0;
        step(4'b0000, 1'b0);
        check("R1 after release", 4'b0000);

        for (int i = 0; i < STEPS; i++) begin
            step(VECS[i].rq, VECS[i].dn);
            checks++;
            if (bus_gnt !== VECS[i].exp) begin
                fails++;
                $display("FAIL R%0d step %0d: bus_gnt=%b expected=%b",
                         VECS[i].rid, i, bus_gnt, VECS[i].exp);
            end
        end

        // R1: reset while a winner is pending must clear it
        step(4'b0010, 1'b0);   // capture device 1
        step(4'b0000, 1'b0);   // device 1 owns
        check("R1 setup", 4'b0010);
        step(4'b0001, 1'b0);   // device 0 pending
        @(negedge clk);
        rst = 1'b1;
        req = '0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        step(4'b0000, 1'b1);
        check("R1 pending cleared", 4'b0000);
        step(4'b0000, 1'b0);
        check("R1 stays idle", 4'b0000);

        // R3 and R4: single low-priority requester on an idle bus
        step(4'b1000, 1'b0);
        check("R4 captured only", 4'b0000);
        step(4'b1000, 1'b0);
        check("R4 idle grant", 4'b1000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule